// File: doc/BRIEF.md
# Banked Pin Configuration Register File

This block holds the configuration of eight ports of eight pins each. A host reaches it over a small register bus made of an address, write data, a write strobe and a combinational read-data return. Five configuration addresses and seven drive-mode addresses are shared by all ports. A bank-select register decides which port those addresses reach, so each port is programmed by first choosing the bank and then writing its settings.

Each pin stores five things: an interrupt mask bit, a PWM-routing bit, an input-inversion bit and a direction bit, plus a 3-bit drive-mode code. The seven drive-mode addresses do not hold data of their own. A 1 written to a bit of mode address k sets that pin's code to k. A later write to another mode address therefore overrides it. A read of mode address k reports, per pin, whether the pin's resolved code is k.

The block also forms the live pin signals. It produces the output enable from the direction bit, the driven value from the output data gated by the pin's PWM source, and the host-visible input value, which is the pad level optionally inverted.

Top module: `port_cfg_bank`

## Requirements
- R1: After reset the bank select reads 0, the mask, PWM-routing, inversion and direction bytes of every port read 0, and every pin has mode code 0 (pull-up), so a read of address 1Dh returns FFh.
- R2: A write of 0 to 7 at address 18h selects that port for addresses 19h to 23h, and a read of 18h returns the selected port.
- R3: A write of a value above 7 to address 18h leaves the selection unchanged.
- R4: Addresses 19h (mask), 1Ah (PWM routing), 1Bh (inversion) and 1Ch (direction) write and read the byte of the selected port only, with bit i for pin i of that port. Other ports keep their values.
- R5: A direction bit of 1 makes the pin an input (`pin_oe` low), and 0 makes it an output (`pin_oe` high). Global pin index = port*8 + bit.
- R6: Mode addresses 1Dh to 23h map to codes 0 to 6 (pull-up, pull-down, open-drain high, open-drain low, strong fast, strong slow, high impedance). A 1 in write bit i sets pin i of the selected port to that code, and a 0 leaves the pin's code unchanged. `pin_mode` carries code p at bits [3p+2:3p].
- R7: The most recent mode write wins for each pin. A read of mode address 1Dh+k returns 1 in bit i exactly when pin i of the selected port currently holds code k.
- R8: `pin_out` equals `out_bits` ANDed with `pwm_in` when the pin's PWM-routing bit is 1, and equals `out_bits` otherwise.
- R9: `in_val` equals `pad_in` XOR the pin's inversion bit. Inversion has no effect on `pin_out`.
- R10: Reads of any address other than 18h to 23h return 0, and writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| out_bits | input | 64 | Output data per pin |
| pwm_in | input | 64 | PWM waveform routed to each pin |
| pad_in | input | 64 | Pad level per pin |
| pin_out | output | 64 | Value to drive per pin |
| pin_oe | output | 64 | Output enable per pin (1 = drive) |
| in_val | output | 64 | Input value after inversion |
| pin_mode | output | 192 | 3-bit drive-mode code per pin |
| irq_mask | output | 64 | Interrupt mask per pin |

## Verification
A register write and a change of the live pin inputs can land in the same cycle. The case that matters is rewriting a port's PWM-routing byte while `pwm_in` changes. The bench drives both on one cycle. It checks `pin_out` before the edge against the old routing with the new waveform, and after the edge against the new routing. It also overlaps mode writes on shared pins and checks that each mode read reflects only the winner.

// File: rtl/port_cfg_bank.sv
module port_cfg_bank #(
  parameter int NPORT = 8,
  parameter int PW    = 8,
  parameter int AW    = 6,
  parameter int MW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [PW-1:0]         wdata,
  output logic [PW-1:0]         rdata,
  input  logic [NPORT*PW-1:0]   out_bits,
  input  logic [NPORT*PW-1:0]   pwm_in,
  input  logic [NPORT*PW-1:0]   pad_in,
  output logic [NPORT*PW-1:0]   pin_out,
  output logic [NPORT*PW-1:0]   pin_oe,
  output logic [NPORT*PW-1:0]   in_val,
  output logic [NPORT*PW*MW-1:0] pin_mode,
  output logic [NPORT*PW-1:0]   irq_mask
);
  localparam int NPIN  = NPORT * PW;
  localparam int SW    = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int NMODE = 7;
  localparam logic [AW-1:0] A_SEL   = AW'(8'h18);
  localparam logic [AW-1:0] A_MASK  = AW'(8'h19);
  localparam logic [AW-1:0] A_PWM   = AW'(8'h1A);
  localparam logic [AW-1:0] A_INV   = AW'(8'h1B);
  localparam logic [AW-1:0] A_DIR   = AW'(8'h1C);
  localparam logic [AW-1:0] A_MODE0 = AW'(8'h1D);

  logic [SW-1:0] sel;
  logic [PW-1:0] mask_q [NPORT];
  logic [PW-1:0] pwm_q  [NPORT];
  logic [PW-1:0] inv_q  [NPORT];
  logic [PW-1:0] dir_q  [NPORT];
  logic [MW-1:0] code_q [NPIN];

  wire          is_mode = (addr >= A_MODE0) && (addr < A_MODE0 + AW'(NMODE));
  wire [AW-1:0] mode_k  = addr - A_MODE0;
  wire          sel_ok  = int'(wdata) < NPORT;
  wire          valid_a = is_mode || (addr >= A_SEL && addr <= A_DIR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0;
      for (int p = 0; p < NPORT; p++) begin
        mask_q[p] <= '0;
        pwm_q[p]  <= '0;
        inv_q[p]  <= '0;
        dir_q[p]  <= '0;
      end
    end else if (wr_en) begin
      if (addr == A_SEL && sel_ok) sel <= wdata[SW-1:0];
      if (addr == A_MASK) mask_q[sel] <= wdata;
      if (addr == A_PWM)  pwm_q[sel]  <= wdata;
      if (addr == A_INV)  inv_q[sel]  <= wdata;
      if (addr == A_DIR)  dir_q[sel]  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPIN; p++) code_q[p] <= '0;
    end else if (wr_en && is_mode) begin
      for (int p = 0; p < NPIN; p++)
        if ((p / PW) == int'(sel) && wdata[p % PW]) code_q[p] <= mode_k[MW-1:0];
    end
  end

  logic [PW-1:0] mode_rd;
  always_comb begin
    for (int b = 0; b < PW; b++)
      mode_rd[b] = (code_q[int'(sel) * PW + b] == mode_k[MW-1:0]);
    rdata = '0;
    if (is_mode) rdata = mode_rd;
    else begin
      case (addr)
        A_SEL:   rdata = PW'(sel);
        A_MASK:  rdata = mask_q[sel];
        A_PWM:   rdata = pwm_q[sel];
        A_INV:   rdata = inv_q[sel];
        A_DIR:   rdata = dir_q[sel];
        default: rdata = '0;
      endcase
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    assign pin_oe[p]   = ~dir_q[p / PW][p % PW];
    assign pin_out[p]  = out_bits[p] & (pwm_q[p / PW][p % PW] ? pwm_in[p] : 1'b1);
    assign in_val[p]   = pad_in[p] ^ inv_q[p / PW][p % PW];
    assign irq_mask[p] = mask_q[p / PW][p % PW];
    assign pin_mode[p*MW +: MW] = code_q[p];

    AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_mode && int'(sel) == p / PW && wdata[p % PW])
      |=> pin_mode[p*MW +: MW] == $past(mode_k[MW-1:0])); // R6
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && is_mode && int'(sel) == p / PW && !wdata[p % PW])
      |=> $stable(pin_mode[p*MW +: MW])); // R6
    AST_OE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_DIR && int'(sel) == p / PW)
      |=> pin_oe[p] == !$past(wdata[p % PW])); // R5
  end

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SEL && !sel_ok) |=> $stable(sel)); // R3
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_a |-> rdata == '0); // R10
endmodule

// File: tb/tb_port_cfg_bank.sv
`timescale 1ns/100ps
module tb_port_cfg_bank;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [63:0] out_bits = '0, pwm_in = '0, pad_in = '0;
  logic [63:0] pin_out, pin_oe, in_val, irq_mask;
  logic [191:0] pin_mode;

  port_cfg_bank dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .out_bits(out_bits), .pwm_in(pwm_in), .pad_in(pad_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .in_val(in_val), .pin_mode(pin_mode), .irq_mask(irq_mask));

  always #2.5 clk = ~clk;

  typedef struct { int kind; logic [63:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic probe = 0, done = 0;

  initial forever begin
    @(negedge clk); #2;
    if (probe && q.size() > 0) begin
      item_t it;
      logic [63:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {56'h0, rdata};
        1: act = pin_out;
        2: act = in_val;
        3: act = pin_oe;
        default: act = pin_mode[63:0];
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input int kind, input logic [5:0] a, input logic [63:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a; it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it); probe = 1;
    @(negedge clk); probe = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(0, 6'h18, 64'h00, "R1 select");
    chk(0, 6'h1D, 64'hFF, "R1 pull-up");
    chk(0, 6'h1C, 64'h00, "R1 dir");
    chk(3, 6'h00, {64{1'b1}}, "R5 reset oe");
    wr(6'h18, 8'd3);
    chk(0, 6'h18, 64'h03, "R2 select");
    wr(6'h1C, 8'hA5);
    chk(0, 6'h1C, 64'hA5, "R4 dir rd");
    chk(3, 6'h00, ~(64'hA5 << 24), "R5 oe");
    wr(6'h18, 8'd9);
    chk(0, 6'h18, 64'h03, "R3 ignore");
    wr(6'h18, 8'd0);
    chk(0, 6'h1C, 64'h00, "R4 other port");
    wr(6'h19, 8'h5A);
    chk(0, 6'h19, 64'h5A, "R4 mask");
    wr(6'h1E, 8'h0F);
    chk(0, 6'h1D, 64'hF0, "R6 pull-up rest");
    chk(0, 6'h1E, 64'h0F, "R6 pull-down");
    wr(6'h1F, 8'h3C);
    chk(0, 6'h1E, 64'h03, "R7 overridden");
    chk(0, 6'h1F, 64'h3C, "R7 winner");
    chk(0, 6'h1D, 64'hC0, "R7 pull-up");
    chk(4, 6'h00, {40'h0, 3'd0,3'd0,3'd2,3'd2,3'd2,3'd2,3'd1,3'd1} , "R6 codes");
    wr(6'h23, 8'h00);
    chk(0, 6'h23, 64'h00, "R6 zero write");
    chk(0, 6'h1F, 64'h3C, "R6 zero keep");
    out_bits = 64'hFF;
    wr(6'h1A, 8'h0F);
    chk(1, 6'h00, 64'hF0, "R8 pwm low");
    pwm_in = '1;
    chk(1, 6'h00, 64'hFF, "R8 pwm high");
    begin
      item_t it;
      @(negedge clk); addr = 6'h1A; wdata = 8'h00; wr_en = 1; pwm_in = '0;
      it.kind = 1; it.exp = 64'hF0; it.tag = "R8 same cycle old";
      q.push_back(it); probe = 1;
      @(negedge clk); wr_en = 0; probe = 0;
    end
    chk(1, 6'h00, 64'hFF, "R8 same cycle new");
    wr(6'h1B, 8'hF0);
    pad_in = 64'h0000_0000_0000_0F0F;
    chk(2, 6'h00, 64'h0000_0000_0000_0FFF, "R9 in_val");
    chk(1, 6'h00, 64'hFF, "R9 no out effect");
    wr(6'h25, 8'hFF);
    chk(0, 6'h25, 64'h00, "R10 read zero");
    chk(0, 6'h19, 64'h5A, "R10 no write");
    chk(0, 6'h18, 64'h00, "R10 select kept");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule